// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial line in asynchronous frames. It accepts either 8-bit frames or 9-bit frames, where the extra bit usually marks an address or carries parity. A host loads bytes through a strobe-qualified write port. A separate strobe loads a ninth-bit register. A baud tick generated outside the block sets the bit period, which is one tick interval.

Between the write port and the shift register sits a holding stage. A host-controlled enable decides how that stage behaves.

- **Enable clear:** the transmitter follows the classic single-buffer discipline. A new byte is accepted only once the current frame has reached its stop bit. The transmit flag rises as the stop bit starts.
- **Enable set:** the host may queue the next byte while the current one is still shifting. The ninth bit is frozen alongside that byte at write time. The transmit flag then means "holding stage free".

Mode 0 always forces the single-buffer discipline, whatever the enable says.

A write that cannot be taken is dropped and raises a sticky collision flag. A queued byte starts on the very tick that ends the previous stop bit, so a stream of queued bytes leaves the line with no idle gap.

Top module: `utx_dbuf_tx`

## Requirements
- R1: After reset the line `tx` is high, `tx_irq` and `wcol` are low, and no byte is pending.
- R2: With `mode` 2'b00 or 2'b01, a frame is one low start bit, then the 8 data bits LSB first, then one high stop bit. Each bit lasts from one `baud_tick` to the next, and `tx` changes only in the cycle after a tick.
- R3: With `mode` 2'b10 or 2'b11, the frame carries a ninth bit between data bit 7 and the stop bit, for 11 bits in total.
- R4: With single buffering, a write is accepted only when no byte is pending and the shifter is idle or sending its stop bit. The ninth bit sent is the ninth-bit register's value when that bit begins.
- R5: With single buffering, `tx_irq` sets in the cycle the stop bit begins on `tx`.
- R6: With double buffering (`dbuf_en`=1 and `mode`≠2'b00), a write is accepted whenever the holding stage is free, even during a frame.
- R7: With double buffering, `tx_irq` sets when the holding stage passes its byte to the shifter.
- R8: With double buffering, the ninth bit is captured together with the byte at the write, including a ninth-bit write in the same cycle. Later ninth-bit writes do not change a queued byte.
- R9: With `mode` 2'b00, `dbuf_en` has no effect and the single-buffer rules of R4 and R5 apply.
- R10: A write that is not accepted sends nothing and sets `wcol` one cycle later.
- R11: `tx_irq` and `wcol` stay set until a one-cycle `clr_irq` or `clr_wcol` pulse clears them. A new setting event in the same cycle wins over the clear.
- R12: A pending byte starts its start bit on the tick that ends the previous stop bit, so back-to-back frames have no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| mode | input | 2 | Frame mode 0..3; modes 2 and 3 add the ninth bit |
| dbuf_en | input | 1 | Double-buffering enable (ignored in mode 0) |
| wr_data | input | 1 | Write strobe for the data byte |
| wr_din | input | DW | Data byte |
| wr_nine | input | 1 | Write strobe for the ninth-bit register |
| nine_din | input | 1 | Ninth-bit value |
| clr_irq | input | 1 | Clears the transmit flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| tx | output | 1 | Serial line, idles high |
| tx_irq | output | 1 | Sticky transmit flag |
| wcol | output | 1 | Sticky write-collision flag |

## Verification
The assertions assume the following about the inputs:

- `baud_tick` is a single-cycle pulse.
- `mode` and `dbuf_en` stay constant while a frame is in flight.
- The strobes are one cycle wide.

The stimulus keeps to these assumptions in three ways. Ticks come from a fixed eight-cycle divider. Mode and buffering are changed only after the line has returned to idle and every expected frame has been received. Every strobe is driven for exactly one cycle on the falling edge.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    UTX_M0 = 2'b00,
    UTX_M1 = 2'b01,
    UTX_M2 = 2'b10,
    UTX_M3 = 2'b11
  } utx_mode_e;

  // frames in modes 2 and 3 carry the extra bit
  function automatic logic utx_is_ext(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/utx_rst_sync.sv
module utx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [DW-1:0] put_data,
  input  logic          put_nine,
  input  logic          put_live,
  input  logic          take,
  output logic          vld,
  output logic [DW-1:0] data,
  output logic          nine,
  output logic          live
);
  logic          vld_q, vld_n;
  logic [DW-1:0] data_q, data_n;
  logic          nine_q, nine_n, live_q, live_n;

  always_comb begin
    vld_n  = vld_q;
    data_n = data_q;
    nine_n = nine_q;
    live_n = live_q;
    if (put) begin
      vld_n  = 1'b1;
      data_n = put_data;
      nine_n = put_nine;
      live_n = put_live;
    end else if (take) begin
      vld_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      nine_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      data_q <= data_n;
      nine_q <= nine_n;
      live_q <= live_n;
    end
  end

  assign vld  = vld_q;
  assign data = data_q;
  assign nine = nine_q;
  assign live = live_q;
endmodule

// File: rtl/utx_shift.sv
module utx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld_vld,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_nine,
  input  logic          ld_live,
  input  logic          ld_ext,
  input  logic          live_nine,
  output logic          tx,
  output logic          busy,
  output logic          in_stop,
  output logic          take,
  output logic          stop_begin
);
  localparam int CW = $clog2(DW + 3);
  localparam logic [CW-1:0] IDX_DATA_END = CW'(DW);
  localparam logic [CW-1:0] IDX_NINE     = CW'(DW + 1);
  localparam logic [CW-1:0] IDX_STOP_EXT = CW'(DW + 2);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc, last_idx;
  logic [DW-1:0] sh_q, sh_n;
  logic          ext_q, ext_n, live_q, live_n, nine_q, nine_n;
  logic          tx_q, tx_n;
  logic          at_last;

  always_comb begin
    last_idx   = ext_q ? IDX_STOP_EXT : IDX_NINE;
    at_last    = busy_q && (cnt_q == last_idx);
    take       = tick && ld_vld && (!busy_q || at_last);
    cnt_inc    = cnt_q + 1'b1;
    busy_n     = busy_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    ext_n      = ext_q;
    live_n     = live_q;
    nine_n     = nine_q;
    tx_n       = tx_q;
    stop_begin = 1'b0;
    if (take) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      sh_n   = ld_data;
      ext_n  = ld_ext;
      live_n = ld_live;
      nine_n = ld_nine;
      tx_n   = 1'b0;
    end else if (tick && at_last) begin
      busy_n = 1'b0;
      tx_n   = 1'b1;
    end else if (tick && busy_q) begin
      cnt_n = cnt_inc;
      if (cnt_inc <= IDX_DATA_END) begin
        tx_n = sh_q[0];
        sh_n = {1'b0, sh_q[DW-1:1]};
      end else if (ext_q && (cnt_inc == IDX_NINE)) begin
        tx_n = live_q ? live_nine : nine_q;
      end else begin
        tx_n = 1'b1;
      end
      stop_begin = (cnt_inc == last_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      ext_q  <= 1'b0;
      live_q <= 1'b0;
      nine_q <= 1'b0;
      tx_q   <= 1'b1;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      ext_q  <= ext_n;
      live_q <= live_n;
      nine_q <= nine_n;
      tx_q   <= tx_n;
    end
  end

  assign tx      = tx_q;
  assign busy    = busy_q;
  assign in_stop = at_last;
endmodule

// File: rtl/utx_dbuf_tx.sv
module utx_dbuf_tx
  import utx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [1:0]    mode,
  input  logic          dbuf_en,
  input  logic          wr_data,
  input  logic [DW-1:0] wr_din,
  input  logic          wr_nine,
  input  logic          nine_din,
  input  logic          clr_irq,
  input  logic          clr_wcol,
  output logic          tx,
  output logic          tx_irq,
  output logic          wcol
);
  logic          rst_ni;
  logic          dbuf_eff, nine_now, accept, collide, irq_set;
  logic          nine_q, nine_n, irq_q, irq_n, wcol_q, wcol_n;
  logic          hold_vld, hold_nine, hold_live;
  logic [DW-1:0] hold_data;
  logic          sh_busy, sh_in_stop, take, stop_begin;

  utx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni)
  );

  always_comb begin
    dbuf_eff = dbuf_en && (mode != UTX_M0);
    nine_now = wr_nine ? nine_din : nine_q;
    accept   = wr_data && !hold_vld && (dbuf_eff || !sh_busy || sh_in_stop);
    collide  = wr_data && !accept;
    irq_set  = dbuf_eff ? take : stop_begin;
    nine_n   = nine_now;
    irq_n    = irq_set || (irq_q && !clr_irq);
    wcol_n   = collide || (wcol_q && !clr_wcol);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      nine_q <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      nine_q <= nine_n;
      irq_q  <= irq_n;
      wcol_q <= wcol_n;
    end
  end

  utx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_ni),
    .put(accept), .put_data(wr_din), .put_nine(nine_now), .put_live(!dbuf_eff),
    .take(take),
    .vld(hold_vld), .data(hold_data), .nine(hold_nine), .live(hold_live)
  );

  utx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_ni), .tick(baud_tick),
    .ld_vld(hold_vld), .ld_data(hold_data), .ld_nine(hold_nine),
    .ld_live(hold_live), .ld_ext(utx_is_ext(mode)), .live_nine(nine_q),
    .tx(tx), .busy(sh_busy), .in_stop(sh_in_stop),
    .take(take), .stop_begin(stop_begin)
  );

  assign tx_irq = irq_q;
  assign wcol   = wcol_q;
endmodule

// File: rtl/utx_dbuf_chk.sv
module utx_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic [1:0] mode,
  input logic       dbuf_en,
  input logic       wr_data,
  input logic       clr_irq,
  input logic       tx,
  input logic       tx_irq,
  input logic       wcol,
  input logic       hold_vld,
  input logic       sh_busy,
  input logic       sh_in_stop
);
  // R2
  tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(baud_tick) |-> $stable(tx));

  // R7
  irq_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(baud_tick));

  // R6
  dbuf_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && mode != 2'b00 && wr_data && !hold_vld && !wcol) |=> !wcol);

  // R9
  mode0_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && wr_data && sh_busy && !sh_in_stop) |=> wcol);

  // R10
  wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(wr_data));

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !clr_irq) |=> tx_irq);

  // R12
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_in_stop && baud_tick && hold_vld) |=> (!tx && sh_busy));
endmodule

bind utx_dbuf_tx utx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
  .dbuf_en(dbuf_en), .wr_data(wr_data), .clr_irq(clr_irq), .tx(tx),
  .tx_irq(tx_irq), .wcol(wcol), .hold_vld(hold_vld), .sh_busy(sh_busy),
  .sh_in_stop(sh_in_stop)
);

// File: tb/tb_utx_dbuf_tx.sv
module tb_utx_dbuf_tx;
  localparam int DW = 8;
  localparam int BITC = 8;

  logic clk, rst_n, baud_tick, dbuf_en, wr_data, wr_nine, nine_din, clr_irq, clr_wcol;
  logic [1:0] mode;
  logic [DW-1:0] wr_din;
  logic tx, tx_irq, wcol;

  int n_chk, n_bad, cyc;
  bit finished;

  int rx_n, exp_n;
  logic [7:0] rx_d [64];
  logic       rx_9 [64];
  logic       rx_ok [64];
  logic       rx_ip [64];
  logic       rx_is [64];
  int         rx_st [64];
  logic [7:0] ex_d [64];
  logic       ex_9 [64];
  logic       ex_x [64];
  logic       ex_f [64];

  utx_dbuf_tx #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode), .dbuf_en(dbuf_en),
    .wr_data(wr_data), .wr_din(wr_din), .wr_nine(wr_nine), .nine_din(nine_din),
    .clr_irq(clr_irq), .clr_wcol(clr_wcol), .tx(tx), .tx_irq(tx_irq), .wcol(wcol)
  );

  initial begin clk = 0; forever #10 clk = ~clk; end
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int tc;
    tc = 0; baud_tick = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % BITC;
      baud_tick = (tc == 0);
    end
  end

  // line receiver
  initial begin
    logic prev, ok, ip, is9, n9;
    logic [7:0] d;
    int nb, st;
    prev = 1; rx_n = 0;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx) begin
        st = cyc; nb = mode[1] ? 11 : 10; d = 0; n9 = 0; ip = 0; is9 = 0;
        repeat (BITC/2) @(negedge clk);
        ok = (tx == 1'b0);
        for (int i = 1; i < nb; i++) begin
          repeat (BITC) @(negedge clk);
          if (i == nb - 2) ip = tx_irq;
          if (i == nb - 1) begin ok = ok & tx; is9 = tx_irq; end
          else if (i <= 8) d[i-1] = tx;
          else n9 = tx;
        end
        if (rx_n < 64) begin
          rx_d[rx_n] = d; rx_9[rx_n] = n9; rx_ok[rx_n] = ok;
          rx_ip[rx_n] = ip; rx_is[rx_n] = is9; rx_st[rx_n] = st;
        end
        rx_n++;
        prev = 1;
      end else prev = tx;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic n9, input logic first);
    ex_d[exp_n] = d; ex_9[exp_n] = n9; ex_x[exp_n] = mode[1]; ex_f[exp_n] = first;
    exp_n++;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); wr_data = 1; wr_din = b;
    @(negedge clk); wr_data = 0;
  endtask

  task automatic wr_9(input logic v);
    @(negedge clk); wr_nine = 1; nine_din = v;
    @(negedge clk); wr_nine = 0;
  endtask

  task automatic clr_both();
    @(negedge clk); clr_irq = 1; clr_wcol = 1;
    @(negedge clk); clr_irq = 0; clr_wcol = 0;
  endtask

  task automatic wait_rx();
    int t;
    t = 0;
    while (rx_n < exp_n && t < 4000) begin @(negedge clk); t++; end
    repeat (200) @(negedge clk);
    chk("R10 frame count", rx_n, exp_n);
  endtask

  task automatic wait_irq();
    int t;
    t = 0;
    while (!tx_irq && t < 400) begin @(negedge clk); t++; end
    chk("R5/R7 flag raised", tx_irq, 1);
    @(negedge clk); clr_irq = 1;
    @(negedge clk); clr_irq = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int bursts, len;
    logic [7:0] d;
    logic n9;
    void'($urandom(32'h5EED_0F11));
    n_chk = 0; n_bad = 0; cyc = 0; exp_n = 0; finished = 0;
    rst_n = 0; mode = 2'b01; dbuf_en = 0; wr_data = 0; wr_din = 0;
    wr_nine = 0; nine_din = 0; clr_irq = 0; clr_wcol = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 tx idle", tx, 1);
    chk("R1 irq clear", tx_irq, 0);
    chk("R1 wcol clear", wcol, 0);

    // mode 1, single: format, flag at stop, mid-frame write rejected
    wr_byte(8'hA5); push(8'hA5, 0, 1);
    repeat (30) @(negedge clk);
    wr_byte(8'h3C);
    chk("R4/R10 single busy write rejected", wcol, 1);
    wait_rx();
    chk("R5 flag low before stop", rx_ip[0], 0);
    chk("R5 flag set at stop", rx_is[0], 1);
    clr_both();
    // R11
    chk("R11 irq cleared", tx_irq, 0);
    chk("R11 wcol cleared", wcol, 0);

    // mode 2, single: ninth bit written after data
    mode = 2'b10;
    wr_9(0);
    wr_byte(8'h5A);
    repeat (10) @(negedge clk);
    wr_9(1); push(8'h5A, 1, 1);
    wait_rx();
    clr_both();

    // mode 3, double buffering
    mode = 2'b11; dbuf_en = 1;
    wr_9(1);
    wr_byte(8'h11); push(8'h11, 1, 1);
    repeat (20) @(negedge clk);
    chk("R7 flag at hand-over", tx_irq, 1);
    clr_both();
    wr_9(0);
    wr_byte(8'h22); push(8'h22, 0, 0);
    chk("R6 queued write accepted", wcol, 0);
    wr_9(1);
    wr_byte(8'h33);
    chk("R10 full write rejected", wcol, 1);
    wait_rx();
    clr_both();

    // mode 0 with buffering requested
    mode = 2'b00; dbuf_en = 1;
    wr_byte(8'h77); push(8'h77, 0, 1);
    repeat (20) @(negedge clk);
    wr_byte(8'h88);
    chk("R9 mode0 forced single", wcol, 1);
    wait_rx();
    chk("R9 mode0 flag at stop", rx_is[exp_n-1], 1);
    clr_both();

    // random bursts
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      mode = 2'($urandom_range(1, 3));
      dbuf_en = 1'($urandom_range(0, 1));
      len = $urandom_range(1, 4);
      for (int k = 0; k < len; k++) begin
        d = 8'($urandom_range(0, 255));
        n9 = 1'($urandom_range(0, 1));
        wr_9(n9);
        wr_byte(d); push(d, n9, k == 0);
        wait_irq();
        chk("R6/R4 burst write accepted", wcol, 0);
      end
      wait_rx();
      clr_both();
    end

    for (int k = 0; k < exp_n && k < 64; k++) begin
      chk("R2 data LSB first", rx_d[k], ex_d[k]);
      chk("R2 start/stop levels", rx_ok[k], 1);
      if (ex_x[k]) chk("R3/R4/R8 ninth bit", rx_9[k], ex_9[k]);
      if (!ex_f[k] && k > 0)
        chk("R12 no idle gap", rx_st[k] - rx_st[k-1], (ex_x[k] ? 11 : 10) * BITC);
    end
    bursts = exp_n;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule